// File: doc/BRIEF.md
# Read-Side Bus Matcher with Byte Swapper

This block is the read port of a 36-bit queue. The queue holds long words made of four 9-bit bytes. The block takes one long word at a time from the head of the queue. The queue shows its head word combinationally and is popped by a one-cycle request. The block can reorder the four bytes in one of four ways. It then delivers the result to a registered output, either as one long word per read, as two 18-bit halves or as four single bytes. Halves and bytes use big- or little-endian lane placement.

The bytes that have not yet been delivered stay in an auxiliary holding register. Later reads at the same size drain that register without touching the queue. The size and endian selects pass through a register, so each one takes effect one edge after it is sampled. A mailbox code on the size select leaves this path and its pending sequence untouched. When parity generation is enabled, each delivered byte has its top bit replaced by a parity bit computed over its lower eight bits.

Top module: `bus_match_reader`

## Requirements
- R1: After a synchronous reset, `dout` is all zero and nothing is held. `data_ready` then follows `q_valid` alone, and the size register holds long-word mode with big-endian placement.
- R2: Size code 0 (long word). Every read pops the queue and places the whole byte-swapped word on `dout`.
- R3: Size code 1 (half word). The first read pops and delivers one 18-bit half, and the second read delivers the other half without a pop. Big-endian puts the upper half first, on lanes 35:18. Little-endian puts the lower half first, on lanes 17:0. The unused lanes read zero.
- R4: Size code 2 (byte). Four reads deliver the bytes, and only the first read pops. Big-endian delivers from the top byte down, on bits 35:27. Little-endian delivers from the bottom byte up, on bits 8:0. The unused bits read zero.
- R5: `size_sel` and `big_endian` are registered on every rising edge. A read uses the values sampled on the previous edge.
- R6: A read made under a registered size that differs from the size of the held word pops a fresh word, and any leftover parts are dropped.
- R7: A read with `size_sel` = 3 is a mailbox access. It causes no pop, leaves `dout` and the held parts unchanged, and does not change the registered size, so the next read continues the interrupted sequence.
- R8: Swap codes act on byte positions A (bits 35:27) to D (bits 8:0): 0 keeps ABCD, 1 gives DCBA, 2 gives CDAB, 3 gives BADC. The code is sampled only on the edge that pops a word and applies to all of that word's parts.
- R9: With `par_gen` high at a read edge, bit 8 of every delivered byte becomes the XOR of its bits 7:0, XORed again with `par_odd`. With `par_gen` low, the stored bit passes through.
- R10: `data_ready` is high when `q_valid` is high, or when parts remain that were loaded under the current registered size. It falls only after the last half or byte of the last word has been read.
- R11: A read with no queue data and no usable held parts causes no pop and leaves `dout` unchanged. No read means no change of `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| size_sel | input | 2 | 0 long word, 1 half word, 2 byte, 3 mailbox access |
| big_endian | input | 1 | Lane placement for half and byte sizes |
| swap_sel | input | 2 | Byte reorder code |
| par_gen | input | 1 | Replace the top bit of each byte by generated parity |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| q_data | input | 36 | Head word of the queue |
| q_valid | input | 1 | Queue holds a word |
| pop | output | 1 | Take the head word this edge |
| dout | output | 36 | Registered output data |
| data_ready | output | 1 | A read would deliver data |

## Verification
The bench aims at the one-edge lag of the size register. A design that applied the size at once would split a word that should leave whole. It checks that a size change drops the leftovers: a design that kept them would deliver stale bytes and skip a pop. A mailbox code inside a byte sequence must not restart the sequence. A design that stored code 3 as the size would pop a new word afterwards. Swap codes changed in the middle of a word must be ignored, or the later bytes come out in the wrong order. `data_ready` must stay high until the final part has been read; a design that lowered it early would strand the bytes still held.

// File: rtl/bus_match_pkg.sv
// Shared types and helpers for the read-side bus matcher.
// Assumes a long word of LANES lanes, each LANE_W bits wide, the top bit of a lane being its parity bit.
package bus_match_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2,
        SZ_MAIL = 2'd3
    } size_t;

    // Number of reads minus one needed to drain a word at a given size.
    function automatic int parts_m1(input size_t sz, input int lanes);
        case (sz)
            SZ_HALF: parts_m1 = 1;
            SZ_BYTE: parts_m1 = lanes - 1;
            default: parts_m1 = 0;
        endcase
    endfunction

    // Lanes carried by one part at a given size.
    function automatic int piece_lanes(input size_t sz, input int lanes);
        case (sz)
            SZ_HALF: piece_lanes = lanes / 2;
            SZ_BYTE: piece_lanes = 1;
            default: piece_lanes = lanes;
        endcase
    endfunction

endpackage

// File: rtl/byte_swapper.sv
// Reorders whole lanes of a long word by a two-bit mode; the bits inside each lane keep their order.
// Assumes an even lane count. Mode 0 keeps the order, 1 reverses it, 2 swaps the halves, 3 swaps neighbours.
module byte_swapper #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SRC_REV  = LANES - 1 - i;
        localparam int SRC_HALF = (i + LANES / 2) % LANES;
        localparam int SRC_PAIR = i ^ 1;

        // Pick the source lane for output lane i.
        always_comb begin
            case (mode)
                2'd1:    dout[i*LANE_W +: LANE_W] = din[SRC_REV*LANE_W  +: LANE_W];
                2'd2:    dout[i*LANE_W +: LANE_W] = din[SRC_HALF*LANE_W +: LANE_W];
                2'd3:    dout[i*LANE_W +: LANE_W] = din[SRC_PAIR*LANE_W +: LANE_W];
                default: dout[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
            endcase
        end
    end

endmodule

// File: rtl/lane_parity.sv
// Optionally replaces the top bit of every lane by parity over the lane's lower bits.
// Assumes even parity makes the lane's total count of ones even; par_odd flips the generated bit.
module lane_parity #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic         enable,
    input  logic         par_odd,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Pass the payload bits and choose the top bit of lane i.
        always_comb begin
            dout[i*LANE_W +: LANE_W-1] = din[i*LANE_W +: LANE_W-1];
            dout[i*LANE_W + LANE_W-1]  = enable
                ? ((^din[i*LANE_W +: LANE_W-1]) ^ par_odd)
                : din[i*LANE_W + LANE_W-1];
        end
    end

endmodule

// File: rtl/lane_picker.sv
// Selects part number `part` of a long word at a given size and places it on the output lanes.
// Assumes part is below the part count for the size. Big-endian starts at the top and fills the top lanes.
// Little-endian starts at the bottom and fills the bottom lanes. Unused lanes are zero.
module lane_picker
    import bus_match_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W,
    localparam int CW    = $clog2(LANES)
) (
    input  size_t        size,
    input  logic         big_endian,
    input  logic [CW-1:0] part,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Map every output lane to a source lane, or to zero.
    always_comb begin
        int pw;
        int np;
        int k;
        int src;
        pw   = piece_lanes(size, LANES);
        np   = LANES / pw;
        k    = int'(part);
        dout = '0;
        for (int i = 0; i < LANES; i++) begin
            src = -1;
            if (big_endian) begin
                if (i >= LANES - pw) src = (np - 1 - k) * pw + (i - (LANES - pw));
            end else begin
                if (i < pw) src = k * pw + i;
            end
            if (src >= 0 && src < LANES) dout[i*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/bus_match_reader.sv
// Read path of a long-word queue with byte reordering and size matching.
// Pops one long word at a time and delivers it whole, as halves or as bytes. Leftover parts
// stay in a holding register. The size and endian selects take effect one edge after sampling.
// Assumes the queue shows its head word combinationally and drops it on an edge with pop high.
module bus_match_reader
    import bus_match_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W,
    localparam int CW    = $clog2(LANES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [1:0]   size_sel,
    input  logic         big_endian,
    input  logic [1:0]   swap_sel,
    input  logic         par_gen,
    input  logic         par_odd,
    input  logic [W-1:0] q_data,
    input  logic         q_valid,
    output logic         pop,
    output logic [W-1:0] dout,
    output logic         data_ready
);

    size_t         size_q;
    logic          be_q;
    size_t         held_size;
    logic [W-1:0]  held_word;
    logic [CW-1:0] remain;
    logic          mbox;
    logic          rd_act;
    logic          need_new;
    logic          drain;
    logic [W-1:0]  swapped;
    logic [W-1:0]  src_word;
    logic [W-1:0]  par_word;
    logic [W-1:0]  lane_out;
    logic [CW-1:0] part_idx;
    logic [CW-1:0] load_left;

    // Decode the strobe and decide between draining the holding register and popping.
    always_comb begin
        mbox     = (size_sel == SZ_MAIL);
        rd_act   = rd_en && !mbox;
        need_new = (remain == '0) || (held_size != size_q);
        pop      = rd_act && need_new && q_valid;
        drain    = rd_act && !need_new;
        load_left = CW'(parts_m1(size_q, LANES));
        part_idx = pop ? '0 : CW'(parts_m1(held_size, LANES) + 1 - int'(remain));
        src_word = pop ? swapped : held_word;
        data_ready = q_valid || ((remain != '0) && (held_size == size_q));
    end

    byte_swapper #(.LANES(LANES), .LANE_W(LANE_W)) i_swap (
        .mode (swap_sel),
        .din  (q_data),
        .dout (swapped)
    );

    lane_parity #(.LANES(LANES), .LANE_W(LANE_W)) i_par (
        .enable  (par_gen),
        .par_odd (par_odd),
        .din     (src_word),
        .dout    (par_word)
    );

    lane_picker #(.LANES(LANES), .LANE_W(LANE_W)) i_pick (
        .size       (size_q),
        .big_endian (be_q),
        .part       (part_idx),
        .din        (par_word),
        .dout       (lane_out)
    );

    // Register the size and endian selects; a mailbox code keeps the previous selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_LONG;
            be_q   <= 1'b1;
        end else if (!mbox) begin
            size_q <= size_t'(size_sel);
            be_q   <= big_endian;
        end
    end

    // Hold the swapped word and count the parts still to be delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            held_size <= SZ_LONG;
            remain    <= '0;
        end else if (pop) begin
            held_word <= swapped;
            held_size <= size_q;
            remain    <= load_left;
        end else if (drain) begin
            remain <= remain - 1'b1;
        end
    end

    // Output register, loaded on every read that delivers a part.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else if (pop || drain) dout <= lane_out;
    end

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> q_valid && rd_en);                                    // R11
    AST_MAIL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && size_sel == 2'd3) |-> !pop);                        // R7
    AST_MAIL_KEEPS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && size_sel == 2'd3) |=> $stable(dout));               // R7
    AST_IDLE_KEEPS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dout) && $stable(remain));                 // R11
    AST_LOAD_USES_REG_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> held_size == $past(size_q));                          // R5
    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (held_size == SZ_HALF) |-> remain <= 1);                      // R3
    AST_LONG_NO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (held_size == SZ_LONG) |-> remain == '0);                     // R2
    AST_STALE_FORCES_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && size_sel != 2'd3 && q_valid && held_size != size_q) |-> pop); // R6
    AST_READY_WHEN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0 && held_size == size_q) |-> data_ready);        // R10

endmodule

// File: tb/test_bus_match_reader.sv
`timescale 1ns/1ps
module test_bus_match_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic        big_endian = 1'b1;
    logic [1:0]  swap_sel = 2'd0;
    logic        par_gen = 1'b0;
    logic        par_odd = 1'b0;
    logic [35:0] q_data = '0;
    logic        q_valid = 1'b0;
    logic        pop;
    logic [35:0] dout;
    logic        data_ready;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_match_reader i_bus_match_reader (
        .clk, .rst_n, .rd_en, .size_sel, .big_endian, .swap_sel,
        .par_gen, .par_odd, .q_data, .q_valid, .pop, .dout, .data_ready
    );

    // Vector: size[42:41] be[40] swap[39:38] pg[37] odd[36] word[35:0]
    localparam int NV = 10;
    localparam logic [42:0] VEC [NV] = '{
        {2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 36'h1_2345_6789},   // R2 plain
        {2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 36'h9_8765_4321},   // R2 R8 reverse
        {2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 36'hA_BCDE_F012},   // R8 halves
        {2'd0, 1'b1, 2'd3, 1'b1, 1'b0, 36'h3_0F0F_5A5A},   // R8 pairs, R9 even
        {2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 36'h4_4332_2110},   // R3 big
        {2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 36'h7_7665_5443},   // R3 little
        {2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 36'hC_1234_ABCD},   // R4 big
        {2'd2, 1'b0, 2'd2, 1'b1, 1'b1, 36'h5_FEDC_BA98},   // R4 little, R9 odd
        {2'd1, 1'b1, 2'd3, 1'b1, 1'b1, 36'hF_FFFF_FFFF},   // R9 odd
        {2'd2, 1'b1, 2'd1, 1'b1, 1'b0, 36'h0_0000_0001}    // R9 even
    };

    // Expected output from the requirements; a[3] is byte A at bits 35:27.
    function automatic logic [35:0] exp_out(input logic [35:0] w, input logic [1:0] sw,
                                            input logic [1:0] sz, input logic be, input int k,
                                            input logic pg, input logic odd);
        logic [8:0] a [4];
        logic [8:0] s [4];
        for (int i = 0; i < 4; i++) a[i] = w[i*9 +: 9];
        case (sw)
            2'd1: begin s[3] = a[0]; s[2] = a[1]; s[1] = a[2]; s[0] = a[3]; end
            2'd2: begin s[3] = a[1]; s[2] = a[0]; s[1] = a[3]; s[0] = a[2]; end
            2'd3: begin s[3] = a[2]; s[2] = a[3]; s[1] = a[0]; s[0] = a[1]; end
            default: begin s[3] = a[3]; s[2] = a[2]; s[1] = a[1]; s[0] = a[0]; end
        endcase
        if (pg) for (int i = 0; i < 4; i++) s[i][8] = (^s[i][7:0]) ^ odd;
        case (sz)
            2'd1: begin
                if (be) exp_out = (k == 0) ? {s[3], s[2], 18'd0} : {s[1], s[0], 18'd0};
                else    exp_out = (k == 0) ? {18'd0, s[1], s[0]} : {18'd0, s[3], s[2]};
            end
            2'd2: begin
                if (be) exp_out = {s[3-k], 27'd0};
                else    exp_out = {27'd0, s[k]};
            end
            default: exp_out = {s[3], s[2], s[1], s[0]};
        endcase
    endfunction

    task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Register a new size/endian with one idle edge (R5).
    task automatic set_size(input logic [1:0] sz, input logic be);
        rd_en = 1'b0; size_sel = sz; big_endian = be; q_valid = 1'b0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [35:0] w;
        logic [35:0] prev;
        repeat (3) step();
        // R1 reset state
        chk("R1 dout after reset", dout, 36'd0);
        chk("R1 ready with empty queue", {35'd0, data_ready}, 36'd0);
        rst_n = 1'b1;
        step();
        chk("R1 ready still low", {35'd0, data_ready}, 36'd0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] sz;
            int np;
            sz = VEC[v][42:41];
            np = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            set_size(sz, VEC[v][40]);
            swap_sel = VEC[v][39:38]; par_gen = VEC[v][37]; par_odd = VEC[v][36];
            for (int k = 0; k < np; k++) begin
                rd_en = 1'b1; q_valid = (k == 0); q_data = VEC[v][35:0];
                #1;
                chk($sformatf("R2/R3/R4 pop vec %0d part %0d", v, k), {35'd0, pop}, {35'd0, k == 0});
                step();
                chk($sformatf("R2/R3/R4/R8/R9 data vec %0d part %0d", v, k), dout,
                    exp_out(VEC[v][35:0], VEC[v][39:38], sz, VEC[v][40], k, VEC[v][37], VEC[v][36]));
            end
            rd_en = 1'b0; q_valid = 1'b0; par_gen = 1'b0;
        end

        // R5: size driven on the same edge as the read still uses the old size (long)
        set_size(2'd0, 1'b1);
        w = 36'h1_1122_3344; swap_sel = 2'd0;
        size_sel = 2'd2; rd_en = 1'b1; q_valid = 1'b1; q_data = w;
        step();
        chk("R5 old size applied", dout, w);
        q_data = 36'h2_5566_7788;
        step();
        chk("R5 new size next edge", dout, exp_out(36'h2_5566_7788, 2'd0, 2'd2, 1'b1, 0, 1'b0, 1'b0));

        // R7: mailbox access mid-sequence, then resume
        rd_en = 1'b1; size_sel = 2'd3; q_valid = 1'b1; q_data = 36'h0_DEAD_BEEF;
        prev = dout;
        #1;
        chk("R7 no pop on mailbox", {35'd0, pop}, 36'd0);
        step();
        chk("R7 dout kept", dout, prev);
        size_sel = 2'd2; q_valid = 1'b0;
        step();
        chk("R7 resume second byte", dout, exp_out(36'h2_5566_7788, 2'd0, 2'd2, 1'b1, 1, 1'b0, 1'b0));

        // R6: size change drops leftovers and pops
        set_size(2'd1, 1'b1);
        rd_en = 1'b1; q_valid = 1'b1; q_data = 36'h6_ABCD_1234;
        #1;
        chk("R6 pop after size change", {35'd0, pop}, 36'd1);
        step();
        chk("R6 fresh word delivered", dout, exp_out(36'h6_ABCD_1234, 2'd0, 2'd1, 1'b1, 0, 1'b0, 1'b0));
        rd_en = 1'b0; q_valid = 1'b0;

        // R10: ready falls only after last half
        #1;
        chk("R10 ready with half left", {35'd0, data_ready}, 36'd1);
        rd_en = 1'b1;
        step();
        chk("R10 second half", dout, exp_out(36'h6_ABCD_1234, 2'd0, 2'd1, 1'b1, 1, 1'b0, 1'b0));
        rd_en = 1'b0;
        #1;
        chk("R10 ready low after last part", {35'd0, data_ready}, 36'd0);

        // R11: read with nothing available
        prev = dout;
        rd_en = 1'b1; q_valid = 1'b0;
        #1;
        chk("R11 no pop when empty", {35'd0, pop}, 36'd0);
        step();
        chk("R11 dout unchanged", dout, prev);

        // R8: swap change mid-word is ignored
        set_size(2'd2, 1'b0);
        w = 36'h9_0123_4567;
        rd_en = 1'b1; q_valid = 1'b1; q_data = w; swap_sel = 2'd1;
        step();
        chk("R8 byte0 with reverse", dout, exp_out(w, 2'd1, 2'd2, 1'b0, 0, 1'b0, 1'b0));
        q_valid = 1'b0;
        for (int k = 1; k < 4; k++) begin
            swap_sel = 2'(k + 1);
            step();
            chk("R8 swap held", dout, exp_out(w, 2'd1, 2'd2, 1'b0, k, 1'b0, 1'b0));
        end
        rd_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule